// File: doc/BRIEF.md
# Control and Status Register Bank with Per-Bit Access Attributes

This block is a small bank of control and status registers on a simple synchronous bus. The bus carries an address, a write strobe with write data, and a read strobe. Read data comes back registered, one clock after the read strobe. Each bit of each register takes its behaviour from an access attribute that is fixed at elaboration by a package function. The attributes are:

- plain read-write
- read-only, which mirrors a hardware value input
- sticky status, which hardware sets and software clears by writing one
- lock-guarded read-write
- self-clearing qualifier
- qualified read-write, which takes a write only when the same write sets the register's qualifier bit
- hard zero

With the default parameters the bank has four 8-bit registers:

- Address 0 is control. Bit 0 is the unlock bit, bits 3:1 are read-write, and bits 7:4 are zero.
- Address 1 is status. Bits 5:0 are sticky status, and bits 7:6 are read-only.
- Address 2 is guarded. Bits 5:0 are lock-guarded, and bits 7:6 are zero.
- Address 3 is qualified. Bit 7 is the qualifier, and bits 6:0 are qualified read-write.

The hardware inputs `hw_set_i` and `hw_val_i` are flat vectors. Register r, bit b sits at position r*8+b. Addresses 4 to 15 are unmapped.

Top module: `csr_attr_bank`

## Requirements
- R1: An asserted `rst_n` (low, asynchronous) clears every stored bit and `rdata_o` to zero.
- R2: A read strobe at a clock edge loads `rdata_o` with the addressed register as it stood before that edge. With no read strobe, `rdata_o` holds its value, even across writes.
- R3: Read-write bits (address 0, bits 3:1 and the unlock bit 0) take the written value on every write.
- R4: A sticky status bit (address 1, bits 5:0) becomes one when its `hw_set_i` bit is high at a clock edge. Hardware never clears it. Writing zero to it leaves it unchanged.
- R5: Writing one to a sticky status bit clears it to zero.
- R6: If `hw_set_i` and a write of one hit the same sticky bit in the same cycle, the bit ends at one.
- R7: Lock-guarded bits (address 2, bits 5:0) take a write only while the unlock bit (address 0, bit 0) is one. Otherwise they keep their value. The unlock bit itself is always writable.
- R8: The qualifier (address 3, bit 7) always reads zero. Bits 6:0 of address 3 are updated only by a write whose bit 7 is one. Otherwise they keep their value.
- R9: Zero bits (address 0, bits 7:4 and address 2, bits 7:6) always read zero. Read-only bits (address 1, bits 7:6) read the `hw_val_i` value present in the read cycle.
- R10: A read of an unmapped address returns zero. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| hw_set_i | input | 32 | Per-bit hardware set events for sticky bits |
| hw_val_i | input | 32 | Per-bit hardware values for read-only bits |

## Verification
A hardware set event and a software write-one-to-clear can land on the same sticky status bit in the same cycle. The bench provokes this with a directed case and with random traffic, in which sparse `hw_set_i` patterns overlap random writes to the status address. A following read judges the result against a bench model in which the set is applied after the clear. A read and a write to the same register in one cycle also coincide. The bench expects such a read to return the value from before the write.

// File: rtl/csr_attr_pkg.sv
package csr_attr_pkg;

  typedef enum logic [2:0] {
    ATTR_ZERO = 3'd0,
    ATTR_RW   = 3'd1,
    ATTR_RO   = 3'd2,
    ATTR_W1C  = 3'd3,
    ATTR_RWL  = 3'd4,
    ATTR_WT   = 3'd5,
    ATTR_QRW  = 3'd6
  } attr_e;

  // Attribute layout: register role repeats every four addresses.
  function automatic attr_e attr_of(input int r, input int b, input int w);
    attr_e a;
    case (r % 4)
      0:       a = (b < w / 2) ? ATTR_RW : ATTR_ZERO;
      1:       a = (b < w - 2) ? ATTR_W1C : ATTR_RO;
      2:       a = (b < w - 2) ? ATTR_RWL : ATTR_ZERO;
      default: a = (b == w - 1) ? ATTR_WT : ATTR_QRW;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode #(
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  output logic [NUM_REGS-1:0] wr_sel_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                mapped_o
);

  always_comb begin
    mapped_o = 1'b0;
    idx_o    = '0;
    wr_sel_o = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr_i == ADDR_W'(r)) begin
        mapped_o    = 1'b1;
        idx_o       = IDX_W'(r);
        wr_sel_o[r] = wr_en_i;
      end
    end
  end

endmodule

// File: rtl/rb_bit.sv
module rb_bit
  import csr_attr_pkg::*;
#(
  parameter attr_e ATTR = ATTR_ZERO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wdata,
  input  logic unlocked,
  input  logic qual,
  input  logic hw_set,
  input  logic hw_val,
  output logic rd_bit
);

  logic q, st_d, st_en;

  // next-state
  always_comb begin
    st_d  = q;
    st_en = wr_hit | hw_set;
    case (ATTR)
      ATTR_RW:  if (wr_hit) st_d = wdata;
      ATTR_RWL: if (wr_hit && unlocked) st_d = wdata;
      ATTR_QRW: if (wr_hit && qual) st_d = wdata;
      ATTR_W1C: begin
        if (wr_hit && wdata) st_d = 1'b0;
        if (hw_set) st_d = 1'b1;
      end
      default:  st_d = 1'b0;
    endcase
  end

  // storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (st_en) q <= st_d;
  end

  always_comb begin
    case (ATTR)
      ATTR_ZERO, ATTR_WT: rd_bit = 1'b0;
      ATTR_RO:            rd_bit = hw_val;
      default:            rd_bit = q;
    endcase
  end

  generate
    if (ATTR == ATTR_W1C) begin : g_w1c_chk
      AST_W1C_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> rd_bit); // R6
      AST_W1C_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bit && !(wr_hit && wdata)) |=> rd_bit); // R4
      AST_W1C_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_bit && !hw_set) |=> !rd_bit); // R4
    end
    if (ATTR == ATTR_RWL) begin : g_rwl_chk
      AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !unlocked) |=> $stable(rd_bit)); // R7
    end
    if (ATTR == ATTR_QRW) begin : g_qrw_chk
      AST_UNQUALIFIED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !qual) |=> $stable(rd_bit)); // R8
    end
  endgenerate

endmodule

// File: rtl/rb_readback.sv
module rb_readback #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en_i,
  input  logic                       mapped_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [NUM_REGS*DATA_W-1:0] rd_vec_i,
  output logic [DATA_W-1:0]          rdata_o
);

  logic [DATA_W-1:0] rd_d;
  logic              rd_ce;

  always_comb begin
    rd_ce = rd_en_i;
    rd_d  = '0;
    if (mapped_i) rd_d = rd_vec_i[idx_i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else if (rd_ce) rdata_o <= rd_d;
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !mapped_i) |=> (rdata_o == '0)); // R10
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R2

endmodule

// File: rtl/csr_attr_bank.sv
module csr_attr_bank
  import csr_attr_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 4,
  parameter int UNLOCK_BIT = 0,
  localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int FLAT_W    = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [FLAT_W-1:0] hw_set_i,
  input  logic [FLAT_W-1:0] hw_val_i
);

  logic [NUM_REGS-1:0] wr_sel;
  logic [IDX_W-1:0]    idx;
  logic                mapped;
  logic [FLAT_W-1:0]   rd_vec;
  logic [NUM_REGS-1:0] qual;
  logic                unlocked;

  // unlock bit lives in register 0 and is plain read-write
  assign unlocked = rd_vec[UNLOCK_BIT];

  rb_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_o (wr_sel),
    .idx_o    (idx),
    .mapped_o (mapped)
  );

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [DATA_W-1:0] wt_hit;
      assign qual[r] = |wt_hit;
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        localparam attr_e A = attr_of(r, b, DATA_W);
        assign wt_hit[b] = (A == ATTR_WT) && wdata_i[b];
        rb_bit #(.ATTR(A)) u_bit (
          .clk      (clk),
          .rst_n    (rst_n),
          .wr_hit   (wr_sel[r]),
          .wdata    (wdata_i[b]),
          .unlocked (unlocked),
          .qual     (qual[r]),
          .hw_set   (hw_set_i[r*DATA_W+b]),
          .hw_val   (hw_val_i[r*DATA_W+b]),
          .rd_bit   (rd_vec[r*DATA_W+b])
        );
      end
    end
  endgenerate

  rb_readback #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en_i  (rd_en_i),
    .mapped_i (mapped),
    .idx_i    (idx),
    .rd_vec_i (rd_vec),
    .rdata_o  (rdata_o)
  );

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !mapped && hw_set_i == '0) |=> $stable(rd_vec[DATA_W-1:0])); // R10
  AST_UNLOCK_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == '0) |=> (unlocked == $past(wdata_i[UNLOCK_BIT]))); // R7

endmodule

// File: tb/sim_csr_attr_bank.sv
module sim_csr_attr_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        we, re;
  logic [7:0]  wd;
  logic [7:0]  rdata;
  logic [31:0] hset, hval;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] m [4];

  always #10 clk = ~clk;

  csr_attr_bank u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rd_en_i(re), .rdata_o(rdata), .hw_set_i(hset), .hw_val_i(hval)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [3:0] a, input logic [31:0] hv);
    case (a)
      4'd0:    return m[0] & 8'h0F;
      4'd1:    return {hv[15:14], m[1][5:0]};
      4'd2:    return m[2] & 8'h3F;
      4'd3:    return m[3] & 8'h7F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R7";
      4'd3: return "R8";
      default: return "R10";
    endcase
  endfunction

  // One bus cycle, entered and left at a falling edge.
  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d,
                      input logic r, input logic [31:0] hs, input logic [31:0] hv,
                      input string tag);
    logic [7:0] exp;
    logic [7:0] nm [4];
    addr = a; we = w; wd = d; re = r; hset = hs; hval = hv;
    exp = rd_model(a, hv);
    nm = m;
    if (w) begin
      case (a)
        4'd0: nm[0] = d & 8'h0F;
        4'd1: nm[1] = m[1] & ~(d & 8'h3F);
        4'd2: if (m[0][0]) nm[2] = d & 8'h3F;
        4'd3: if (d[7]) nm[3] = d & 8'h7F;
        default: ;
      endcase
    end
    nm[1] = nm[1] | {2'b00, hs[13:8]};
    @(posedge clk);
    m = nm;
    @(negedge clk);
    we = 1'b0; re = 1'b0; hset = '0;
    if (r) check((tag == "") ? tag_of(a) : tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4; i++) m[i] = 8'h00;
    rst_n = 1'b0; addr = '0; we = 0; wd = '0; re = 0; hset = '0; hval = '0;
    repeat (3) @(negedge clk);
    check("R1", rdata, 8'h00);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) step(4'(a), 0, 8'h00, 1, '0, '0, "R1");

    // R3 read-write, R9 zero bits of control
    step(0, 1, 8'hFF, 0, '0, '0, "");
    step(0, 0, 8'h00, 1, '0, '0, "R3");
    step(0, 1, 8'hF5, 1, '0, '0, "R9");   // read sees old value 0F
    step(0, 0, 8'h00, 1, '0, '0, "R3");   // 05

    // R2 hold while no read strobe
    held = rdata;
    step(0, 1, 8'h01, 0, '0, '0, "");
    check("R2", rdata, held);

    // R4 / R5 sticky status
    step(1, 0, 8'h00, 0, 32'h0000_0400, '0, "");
    step(1, 0, 8'h00, 1, '0, '0, "R4");
    step(1, 1, 8'h00, 0, '0, '0, "");
    step(1, 0, 8'h00, 1, '0, '0, "R4");
    step(1, 1, 8'h04, 0, '0, '0, "");
    step(1, 0, 8'h00, 1, '0, '0, "R5");
    // R6 set and clear collide
    step(1, 0, 8'h00, 0, 32'h0000_0800, '0, "");
    step(1, 1, 8'h08, 0, 32'h0000_0800, '0, "");
    step(1, 0, 8'h00, 1, '0, '0, "R6");
    check("R6", rdata, 8'h08);

    // R7 lock
    step(0, 1, 8'h00, 0, '0, '0, "");
    step(2, 1, 8'h3F, 0, '0, '0, "");
    step(2, 0, 8'h00, 1, '0, '0, "R7");
    check("R7", rdata, 8'h00);
    step(0, 1, 8'h01, 0, '0, '0, "");
    step(2, 1, 8'hEA, 0, '0, '0, "");
    step(2, 0, 8'h00, 1, '0, '0, "R7");
    check("R9", rdata, 8'h2A);

    // R8 qualifier
    step(3, 1, 8'h55, 0, '0, '0, "");
    step(3, 0, 8'h00, 1, '0, '0, "R8");
    step(3, 1, 8'hD5, 0, '0, '0, "");
    step(3, 0, 8'h00, 1, '0, '0, "R8");
    check("R8", rdata, 8'h55);

    // R9 read-only bits
    step(1, 0, 8'h00, 1, '0, 32'h0000_8000, "R9");

    // R10 unmapped
    step(9, 1, 8'hFF, 0, '0, '0, "");
    step(9, 0, 8'h00, 1, '0, '0, "R10");
    for (int a = 0; a < 4; a++) step(4'(a), 0, 8'h00, 1, '0, '0, "R10");

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      a = ($urandom_range(0, 9) < 8) ? 4'($urandom_range(0, 3)) : 4'($urandom_range(4, 15));
      step(a, 1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 2) != 0),
           $urandom & $urandom & $urandom, $urandom, "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule